// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a clock generator and the clock pins. It takes CPU, PCI and reference clock sources and drives gated copies of them under three active-low controls: a CPU stop request, a PCI stop request and a power-down request. Every source arrives as an ideal digital waveform, oversampled on a fast master clock `clk`. All gating is synchronous to `clk`. Each gate enable can change only in a master cycle where its source is sampled low. A gated output therefore always shows whole high phases and never a runt pulse.

The CPU source is taken from one of two inputs, a fast one and a slow one. A speed select picks the input, and it is captured once when reset is released. The CPU stop and power-down requests pass through a two-stage synchronizer in the CPU domain, which gives a stop or restart latency of two to three CPU cycles. The PCI stop request is captured on a single rising edge of the free-running PCI source and takes effect on the next PCI cycle. The free-running PCI output and the reference output ignore both stop requests and respond only to power-down.

A power state machine has four states: `ST_RUN`, `ST_DRAIN`, `ST_SLEEP` and `ST_WAKE`. Its transitions are as follows:
- RUN to DRAIN when the synchronized power-down input goes low.
- DRAIN to SLEEP once every gate enable is off.
- SLEEP to WAKE when power-down is released, with the wake counter cleared.
- WAKE back to SLEEP if power-down drops again.
- WAKE to RUN once `WAKE_REF_CYCLES` reference rising edges have been counted.

The default count stands for 3 ms of a 14.318 MHz reference.

Top module: `clk_stop_ctrl`

## Requirements
- R1: At each `clk` edge after reset is released, `fast_mode` holds the value that `sel_fast` had at the first rising edge of `clk` after the release. While `fast_mode` is 1 the CPU outputs follow `src_cpu_fast`, and otherwise they follow `src_cpu_slow`.
- R2: When `cpu_stop_n` goes low, the CPU outputs finish any high phase already under way and then stay at 0. The first suppressed high phase is the one that starts at the second or third CPU source rising edge after the request. All `NCPU` bits are always identical.
- R3: When `cpu_stop_n` returns high, the CPU outputs resume with a complete high phase within three CPU source cycles, and `cpu_running` reads 1.
- R4: `pci_stop_n` is sampled on a rising edge of `src_pci`. The gated PCI outputs change state from the next PCI source cycle on, and they stay at 0 while the sampled value is 0.
- R5: `pci_free_clk` reproduces `src_pci` (one `clk` later) regardless of `pci_stop_n`.
- R6: When `pwr_dn_n` goes low, every output ends its current high phase and goes to 0. `sleeping` reads 1 once all gates are off, and all clock outputs stay at 0 while `sleeping` is 1.
- R7: When `pwr_dn_n` is released, all clock outputs stay at 0 until `WAKE_REF_CYCLES` rising edges of `src_ref` have been counted. After that `sleeping` reads 0 and the clocks restart with full cycles.
- R8: A low level on `pwr_dn_n` during the wake count returns the block to sleep, and the count starts again from zero at the next release.
- R9: No gated output ever shows a high pulse shorter than its source's high phase.
- R10: `cpu_running` and `pci_running` report the CPU and PCI gate enables, and they change only in cycles that follow a low sample of the matching source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_cpu_fast | input | 1 | Fast CPU clock source |
| src_cpu_slow | input | 1 | Slow CPU clock source |
| src_pci | input | 1 | PCI clock source |
| src_ref | input | 1 | Reference clock source |
| sel_fast | input | 1 | CPU speed select, captured after reset |
| cpu_stop_n | input | 1 | Active-low CPU clock stop request |
| pci_stop_n | input | 1 | Active-low PCI clock stop request |
| pwr_dn_n | input | 1 | Active-low power-down request |
| cpu_clk | output | NCPU | Gated CPU clocks |
| pci_clk | output | NPCI | Gated PCI clocks |
| pci_free_clk | output | 1 | Free-running PCI clock (power-down only) |
| ref_clk | output | 1 | Reference clock (power-down only) |
| cpu_running | output | 1 | CPU gate enable status |
| pci_running | output | 1 | PCI gate enable status |
| sleeping | output | 1 | High in the SLEEP and WAKE states |
| fast_mode | output | 1 | Captured speed select |

## Verification
The hardest situation to reach is a power-down request that falls again while the wake counter is partway through its count. In that case the counter must restart instead of resuming. The stimulus releases power-down, lets a few reference edges be counted, then pulses `pwr_dn_n` low for three master cycles and releases it again. It then checks that the block is still asleep at a point where a counter that had not restarted would already have woken. Stop requests are also issued at each phase offset of the CPU source, so that both the two-cycle and the three-cycle latency occur.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/clkstop_sel.sv
module clkstop_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fast,
    input  logic src_fast,
    input  logic src_slow,
    output logic fast_mode,
    output logic cpu_src
);
    logic armed;
    logic fast_q;

    // armed is low through reset and for the first edge after release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // the select is tracked until armed, then held
    always_ff @(posedge clk) begin
        if (!armed) fast_q <= sel_fast;
    end

    assign fast_mode = fast_q;
    assign cpu_src   = fast_q ? src_fast : src_slow;
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int WIDTH = 1,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src,
    input  logic             want,
    output logic [WIDTH-1:0] gclk,
    output logic             on
);
    logic src_d;
    logic sync_out;
    logic gq;
    logic rise;

    assign rise = src & ~src_d;

    // the request is sampled only on source rising edges
    generate
        if (SYNC == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    sync_out <= 1'b0;
                else if (rise) sync_out <= want;
            end
        end else begin : g_chain
            logic [SYNC-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else if (rise) begin
                    chain[0] <= want;
                    for (int i = 1; i < SYNC; i++) chain[i] <= chain[i-1];
                end
            end
            assign sync_out = chain[SYNC-1];
        end
    endgenerate

    // the enable moves only while the source is low: whole phases only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_d <= 1'b0;
            on    <= 1'b0;
            gq    <= 1'b0;
        end else begin
            src_d <= src;
            if (!src) on <= sync_out;
            gq <= src & on;
        end
    end

    assign gclk = {WIDTH{gq}};
endmodule

// File: rtl/clkstop_pwr_fsm.sv
module clkstop_pwr_fsm
    import clkstop_pkg::*;
#(
    parameter int WAKE_REF_CYCLES = 42955
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn_n,
    input  logic ref_src,
    input  logic all_off,
    output logic run_ok,
    output logic sleeping
);
    localparam int CW = $clog2(WAKE_REF_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_REF_CYCLES - 1);

    pwr_state_e state, state_nx;
    logic       pd_s1, pd_s2;
    logic       ref_d;
    logic       ref_rise;
    logic [CW-1:0] cnt;

    assign ref_rise = ref_src & ~ref_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_s1 <= 1'b1;
            pd_s2 <= 1'b1;
            ref_d <= 1'b0;
        end else begin
            pd_s1 <= pwr_dn_n;
            pd_s2 <= pd_s1;
            ref_d <= ref_src;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (!pd_s2)  state_nx = ST_DRAIN;
            ST_DRAIN: if (all_off) state_nx = ST_SLEEP;
            ST_SLEEP: if (pd_s2)   state_nx = ST_WAKE;
            ST_WAKE: begin
                if (!pd_s2)                        state_nx = ST_SLEEP;
                else if (ref_rise && cnt == LAST)  state_nx = ST_RUN;
            end
            default:                               state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // wake counter: cleared while asleep, advances on reference rises
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               cnt <= '0;
        else if (state != ST_WAKE)                cnt <= '0;
        else if (ref_rise && cnt != LAST)         cnt <= cnt + 1'b1;
    end

    always_comb begin
        run_ok   = (state == ST_RUN);
        sleeping = (state == ST_SLEEP) || (state == ST_WAKE);
    end
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
    parameter int NCPU            = 2,
    parameter int NPCI            = 5,
    parameter int WAKE_REF_CYCLES = 42955
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_cpu_fast,
    input  logic            src_cpu_slow,
    input  logic            src_pci,
    input  logic            src_ref,
    input  logic            sel_fast,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic            pwr_dn_n,
    output logic [NCPU-1:0] cpu_clk,
    output logic [NPCI-1:0] pci_clk,
    output logic            pci_free_clk,
    output logic            ref_clk,
    output logic            cpu_running,
    output logic            pci_running,
    output logic            sleeping,
    output logic            fast_mode
);
    localparam int CPU_SYNC = 2;
    localparam int PCI_SYNC = 1;

    logic cpu_src_sel;
    logic run_ok;
    logic free_on, ref_on;
    logic all_off;
    logic want_cpu, want_pci, want_fixed;

    assign want_cpu   = cpu_stop_n & pwr_dn_n & run_ok;
    assign want_pci   = pci_stop_n & pwr_dn_n & run_ok;
    assign want_fixed = pwr_dn_n & run_ok;
    assign all_off    = ~(cpu_running | pci_running | free_on | ref_on);

    clkstop_sel u_sel (
        .clk(clk), .rst_n(rst_n), .sel_fast(sel_fast),
        .src_fast(src_cpu_fast), .src_slow(src_cpu_slow),
        .fast_mode(fast_mode), .cpu_src(cpu_src_sel)
    );

    clkstop_gate #(.WIDTH(NCPU), .SYNC(CPU_SYNC)) u_cpu (
        .clk(clk), .rst_n(rst_n), .src(cpu_src_sel), .want(want_cpu),
        .gclk(cpu_clk), .on(cpu_running)
    );

    clkstop_gate #(.WIDTH(NPCI), .SYNC(PCI_SYNC)) u_pci (
        .clk(clk), .rst_n(rst_n), .src(src_pci), .want(want_pci),
        .gclk(pci_clk), .on(pci_running)
    );

    clkstop_gate #(.WIDTH(1), .SYNC(PCI_SYNC)) u_free (
        .clk(clk), .rst_n(rst_n), .src(src_pci), .want(want_fixed),
        .gclk(pci_free_clk), .on(free_on)
    );

    clkstop_gate #(.WIDTH(1), .SYNC(PCI_SYNC)) u_ref (
        .clk(clk), .rst_n(rst_n), .src(src_ref), .want(want_fixed),
        .gclk(ref_clk), .on(ref_on)
    );

    clkstop_pwr_fsm #(.WAKE_REF_CYCLES(WAKE_REF_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .ref_src(src_ref),
        .all_off(all_off), .run_ok(run_ok), .sleeping(sleeping)
    );
endmodule

// File: rtl/clkstop_checker.sv
module clkstop_checker #(
    parameter int NCPU = 2,
    parameter int NPCI = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_src,
    input logic            pci_src,
    input logic [NCPU-1:0] cpu_clk,
    input logic [NPCI-1:0] pci_clk,
    input logic            pci_free_clk,
    input logic            ref_clk,
    input logic            cpu_running,
    input logic            pci_running,
    input logic            sleeping
);
    assert_cpu_en_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_running) |-> !$past(cpu_src));

    assert_pci_en_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pci_running) |-> !$past(pci_src));

    assert_pci_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_running |=> (pci_clk == '0));

    assert_sleep_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping |-> (cpu_clk == '0 && pci_clk == '0 && !pci_free_clk && !ref_clk));

    assert_cpu_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk[0]) |-> $past(cpu_running));

    assert_cpu_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk[0]) |-> (cpu_clk == {NCPU{1'b1}}));
endmodule

bind clk_stop_ctrl clkstop_checker #(.NCPU(NCPU), .NPCI(NPCI)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src_sel), .pci_src(src_pci),
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_free_clk(pci_free_clk),
    .ref_clk(ref_clk), .cpu_running(cpu_running), .pci_running(pci_running),
    .sleeping(sleeping)
);

// File: tb/sim_clk_stop_ctrl.sv
`timescale 1ns/1ps
module sim_clk_stop_ctrl;
    localparam int NCPU = 2;
    localparam int NPCI = 5;
    localparam int WAKE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_cpu_fast = 1'b0, src_cpu_slow = 1'b0, src_pci = 1'b0, src_ref = 1'b0;
    logic sel_fast = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic [NCPU-1:0] cpu_clk;
    logic [NPCI-1:0] pci_clk;
    logic pci_free_clk, ref_clk, cpu_running, pci_running, sleeping, fast_mode;

    int checks = 0, errors = 0, cyc = 0, ph = 0;
    bit chk_on = 0;

    always #2.5 clk = ~clk;

    clk_stop_ctrl #(.NCPU(NCPU), .NPCI(NPCI), .WAKE_REF_CYCLES(WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .src_cpu_fast(src_cpu_fast), .src_cpu_slow(src_cpu_slow),
        .src_pci(src_pci), .src_ref(src_ref), .sel_fast(sel_fast), .cpu_stop_n(cpu_stop_n),
        .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n), .cpu_clk(cpu_clk), .pci_clk(pci_clk),
        .pci_free_clk(pci_free_clk), .ref_clk(ref_clk), .cpu_running(cpu_running),
        .pci_running(pci_running), .sleeping(sleeping), .fast_mode(fast_mode)
    );

    // source waveforms: periods 4, 6, 12 and 14 master cycles
    always @(negedge clk) begin
        ph++;
        src_cpu_fast = (ph % 4) < 2;
        src_cpu_slow = (ph % 6) < 3;
        src_pci      = (ph % 12) < 6;
        src_ref      = (ph % 14) < 7;
    end

    // behavioural reference: 0 cpu, 1 pci, 2 free pci, 3 ref
    int m_state = 0, m_cnt = 0;
    bit m_p1 = 1, m_p2 = 1, m_armed = 0, m_fast = 0;
    bit m_prev[4], m_en[4], m_g[4];
    bit m_hist[4][$];
    int sync_len[4] = '{2, 1, 1, 1};

    always @(posedge clk) begin
        bit s[4];
        bit w[4];
        bit run, off, rr;
        s[0] = m_fast ? src_cpu_fast : src_cpu_slow;
        s[1] = src_pci; s[2] = src_pci; s[3] = src_ref;
        if (!rst_n || !m_armed) m_fast = sel_fast;
        m_armed = rst_n;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_p1 = 1; m_p2 = 1;
            for (int d = 0; d < 4; d++) begin
                m_prev[d] = 0; m_en[d] = 0; m_g[d] = 0; m_hist[d].delete();
            end
        end else begin
            run  = (m_state == 0);
            w[0] = cpu_stop_n & pwr_dn_n & run;
            w[1] = pci_stop_n & pwr_dn_n & run;
            w[2] = pwr_dn_n & run;
            w[3] = w[2];
            off  = !(m_en[0] | m_en[1] | m_en[2] | m_en[3]);
            rr   = s[3] & !m_prev[3];
            for (int d = 0; d < 4; d++) begin
                m_g[d] = s[d] & m_en[d];
                if (s[d] && !m_prev[d]) begin
                    m_hist[d].push_front(w[d]);
                    if (m_hist[d].size() > 4) void'(m_hist[d].pop_back());
                end
                if (!s[d]) m_en[d] = (m_hist[d].size() >= sync_len[d]) ? m_hist[d][sync_len[d]-1] : 1'b0;
                m_prev[d] = s[d];
            end
            case (m_state)
                0: if (!m_p2) m_state = 1;
                1: if (off) m_state = 2;
                2: begin m_cnt = 0; if (m_p2) m_state = 3; end
                default: begin
                    if (!m_p2) m_state = 2;
                    else if (rr) begin
                        if (m_cnt == WAKE - 1) m_state = 0;
                        else m_cnt++;
                    end
                end
            endcase
            m_p2 = m_p1; m_p1 = pwr_dn_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, pulse widths and rise counters
    int len[4];
    int rises[4];
    always @(negedge clk) begin
        bit o[4];
        int half[4];
        if (rst_n && chk_on) begin
            check(cpu_clk == {NCPU{m_g[0]}}, "R2 cpu_clk", int'(cpu_clk), m_g[0] ? (1 << NCPU) - 1 : 0);
            check(pci_clk == {NPCI{m_g[1]}}, "R4 pci_clk", int'(pci_clk), m_g[1] ? (1 << NPCI) - 1 : 0);
            check(pci_free_clk == m_g[2], "R5 pci_free_clk", pci_free_clk, m_g[2]);
            check(ref_clk == m_g[3], "R6 ref_clk", ref_clk, m_g[3]);
            check(cpu_running == m_en[0], "R10 cpu_running", cpu_running, m_en[0]);
            check(pci_running == m_en[1], "R10 pci_running", pci_running, m_en[1]);
            check(sleeping == (m_state >= 2), "R6 sleeping", sleeping, m_state >= 2);
            check(fast_mode == m_fast, "R1 fast_mode", fast_mode, m_fast);
        end
        o[0] = cpu_clk[0]; o[1] = pci_clk[0]; o[2] = pci_free_clk; o[3] = ref_clk;
        half[0] = m_fast ? 2 : 3; half[1] = 6; half[2] = 6; half[3] = 7;
        for (int d = 0; d < 4; d++) begin
            if (!rst_n) len[d] = 0;
            else if (o[d]) begin
                if (len[d] == 0) rises[d]++;
                len[d]++;
            end else begin
                if (len[d] != 0 && chk_on) check(len[d] >= half[d], "R9 high pulse", len[d], half[d]);
                len[d] = 0;
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int snap[4];
        wait_n(5);
        rst_n = 1'b1;
        chk_on = 1'b1;
        wait_n(20);
        check(fast_mode == 1'b1, "R1 select fast", fast_mode, 1);
        snap = rises; wait_n(48);
        check(rises[0] - snap[0] == 12, "R1 fast rate", rises[0] - snap[0], 12);

        cpu_stop_n = 1'b0; wait_n(20);
        snap = rises; wait_n(40);
        check(rises[0] == snap[0], "R2 cpu stopped", rises[0] - snap[0], 0);
        cpu_stop_n = 1'b1; wait_n(16);
        check(cpu_running == 1'b1, "R3 cpu resumed", cpu_running, 1);
        snap = rises; wait_n(40);
        check(rises[0] - snap[0] == 10, "R3 cpu rate", rises[0] - snap[0], 10);
        for (int k = 0; k < 4; k++) begin
            wait_n(k + 1); cpu_stop_n = 1'b0;
            wait_n(30);    cpu_stop_n = 1'b1;
            wait_n(30);
        end

        pci_stop_n = 1'b0; wait_n(30);
        snap = rises; wait_n(48);
        check(rises[1] == snap[1], "R4 pci stopped", rises[1] - snap[1], 0);
        check(rises[2] - snap[2] == 4, "R5 free pci runs", rises[2] - snap[2], 4);
        pci_stop_n = 1'b1; wait_n(30);

        pwr_dn_n = 1'b0; wait_n(60);
        check(sleeping == 1'b1, "R6 asleep", sleeping, 1);
        snap = rises; wait_n(40);
        check(rises[0] + rises[1] + rises[2] + rises[3] == snap[0] + snap[1] + snap[2] + snap[3],
              "R6 all quiet", rises[3] - snap[3], 0);
        pwr_dn_n = 1'b1; wait_n(40);
        check(sleeping == 1'b1, "R7 still waking", sleeping, 1);
        check(rises[0] == snap[0], "R7 cpu held low", rises[0] - snap[0], 0);
        wait_n(100);
        check(sleeping == 1'b0, "R7 awake", sleeping, 0);
        wait_n(30);
        snap = rises; wait_n(48);
        check(rises[0] - snap[0] == 12, "R7 cpu restarted", rises[0] - snap[0], 12);

        pwr_dn_n = 1'b0; wait_n(60);
        pwr_dn_n = 1'b1; wait_n(50);
        pwr_dn_n = 1'b0; wait_n(3);
        pwr_dn_n = 1'b1; wait_n(70);
        check(sleeping == 1'b1, "R8 count restarted", sleeping, 1);
        wait_n(120);
        check(sleeping == 1'b0, "R8 awake after restart", sleeping, 0);

        rst_n = 1'b0; sel_fast = 1'b0; wait_n(5);
        rst_n = 1'b1; wait_n(30);
        check(fast_mode == 1'b0, "R1 select slow", fast_mode, 0);
        snap = rises; wait_n(60);
        check(rises[0] - snap[0] == 10, "R1 slow rate", rises[0] - snap[0], 10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule